// File: doc/BRIEF.md
# Passive LCD Panel Timing Generator

This block produces the line, frame and shift-clock waveforms needed to drive a passive matrix LCD panel, together with the panel data bus. A free-running divider turns the input clock into a pixel-period enable, and every interval the block produces is a whole number of these pixel periods. A line is made of a shifting section, a quiet tail, a horizontal sync pulse and, on the first line of a frame only, a lead-in gap that ends in the vertical sync.

Pixel words come in on a ready/valid stream, one word per shift clock. The block requests a word at the instant a new shift period begins and drives it onto the panel bus while the shift clock is inactive, so the word is steady at the active edge. If no word is offered when one is needed, the previous word stays on the bus and a sticky underrun flag is raised. All geometry, the bus-width selection and the three sync polarities are static configuration inputs.

Top module: `passive_lcd_timing`

## Requirements
- R1: One pixel period is `cfg_pix_div + 1` input clock cycles; every interval below is counted in pixel periods.
- R2: `cfg_bus_sel` selects the shift period as 2, 4, 8 or 16 pixel periods for codes 0, 1, 2 and 3. Within each shift period the shift clock is inactive for the first half and active for the second half.
- R3: Each line shifts `cfg_line_px` pixel periods (a nonzero multiple of the shift period), giving `cfg_line_px` / shift-period shift clocks. `px_ready` is high for one input clock at the start of each shift period, and never while the shift clock is active in the following cycle.
- R4: The horizontal sync pulse lasts `cfg_hs_width + 1` pixel periods.
- R5: From the inactive edge of the last shift clock in a line to the assertion of horizontal sync there are `cfg_gap_tail + 1` pixel periods, with no shift clock and no horizontal sync in between.
- R6: On the first line of a frame, vertical sync asserts `cfg_gap_vs + 2` pixel periods after horizontal sync deasserts and stays asserted for the `cfg_line_px` shifting pixel periods. On other lines the first shift clock's active edge comes half a shift period after horizontal sync deasserts.
- R7: The first shift clock's active edge comes half a shift period after vertical sync asserts, which is within one shift period.
- R8: Exactly `cfg_frame_lines` horizontal syncs occur from one vertical sync to the next (a value of 0 acts as 1), and vertical sync never overlaps horizontal sync.
- R9: Each of `lcd_vsync`, `lcd_hsync` and `lcd_sclk` is active high when its polarity input is 1 and active low when it is 0.
- R10: `lcd_data` changes only at the start of a shift period, is steady while the shift clock is active, and carries the stream words in arrival order.
- R11: If `px_valid` is low when a word is requested, `lcd_data` keeps its previous word and `underrun` goes high and stays high until reset.
- R12: In reset all three syncs are inactive, `lcd_data` is zero and `underrun` is low; after reset the first horizontal sync is followed by the first frame's vertical sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input LCD clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pix_div | input | DIV_W | Pixel period minus one, in clocks |
| cfg_line_px | input | CNT_W | Shifting pixel periods per line |
| cfg_hs_width | input | CNT_W | Horizontal sync width minus one |
| cfg_gap_tail | input | CNT_W | Last shift clock to horizontal sync gap minus one |
| cfg_gap_vs | input | CNT_W | Horizontal sync end to vertical sync gap minus two |
| cfg_bus_sel | input | 2 | Shift period code (2, 4, 8, 16 pixel periods) |
| cfg_frame_lines | input | LINE_W | Lines per frame |
| cfg_vs_high | input | 1 | Vertical sync polarity, 1 = active high |
| cfg_hs_high | input | 1 | Horizontal sync polarity, 1 = active high |
| cfg_sc_high | input | 1 | Shift clock polarity, 1 = active high |
| px_valid | input | 1 | Stream word offered |
| px_data | input | DATA_W | Stream word |
| px_ready | output | 1 | Stream word taken this cycle |
| lcd_vsync | output | 1 | Vertical sync |
| lcd_hsync | output | 1 | Horizontal sync |
| lcd_sclk | output | 1 | Shift clock |
| lcd_data | output | DATA_W | Panel data bus |
| underrun | output | 1 | Sticky stream underrun flag |

## Verification
The assertions take the configuration and polarity inputs as constant whenever reset is released, and they judge sync and shift-clock activity through those polarity inputs. They also rely on the line length being a nonzero multiple of the selected shift period. The bench changes configuration only while reset is held, always picks line lengths as whole numbers of shift periods, and withholds stream words only in one dedicated run that provokes the underrun path.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    typedef enum logic [1:0] {
        ST_TAIL   = 2'd0,
        ST_HSYNC  = 2'd1,
        ST_VLEAD  = 2'd2,
        ST_ACTIVE = 2'd3
    } ptg_state_e;

endpackage

// File: rtl/ptg_pixdiv.sv
module ptg_pixdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);

    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        tick  = (div_q >= div_val);
        div_d = tick ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

endmodule

// File: rtl/ptg_seq.sv
module ptg_seq
    import ptg_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CNT_W-1:0]  cfg_line_px,
    input  logic [CNT_W-1:0]  cfg_hs_width,
    input  logic [CNT_W-1:0]  cfg_gap_tail,
    input  logic [CNT_W-1:0]  cfg_gap_vs,
    input  logic [1:0]        cfg_bus_sel,
    input  logic [LINE_W-1:0] cfg_frame_lines,
    output logic              hs_act,
    output logic              vs_act,
    output logic              sc_act,
    output logic              load
);

    typedef struct packed {
        ptg_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [LINE_W-1:0] line;
        logic              first;
    } seq_t;

    seq_t r_d, r_q;

    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] shift_mask;
    logic [4:0]       shift_len;
    logic [LINE_W:0]  line_inc;
    logic             wrap;

    always_comb begin
        unique case (r_q.state)
            ST_TAIL:   limit = cfg_gap_tail;
            ST_HSYNC:  limit = cfg_hs_width;
            ST_VLEAD:  limit = cfg_gap_vs + 1'b1;
            default:   limit = cfg_line_px - 1'b1;
        endcase
        shift_len  = 5'd2 << cfg_bus_sel;
        shift_mask = CNT_W'(shift_len - 5'd1);
        line_inc   = {1'b0, r_q.line} + 1'b1;
        wrap       = (line_inc >= {1'b0, cfg_frame_lines});
    end

    always_comb begin
        r_d = r_q;
        if (tick) begin
            if (r_q.cnt == limit) begin
                r_d.cnt = '0;
                unique case (r_q.state)
                    ST_TAIL:  r_d.state = ST_HSYNC;
                    ST_HSYNC: begin
                        r_d.first = 1'b0;
                        if (r_q.first || wrap) begin
                            r_d.line  = '0;
                            r_d.state = ST_VLEAD;
                        end else begin
                            r_d.line  = r_q.line + 1'b1;
                            r_d.state = ST_ACTIVE;
                        end
                    end
                    ST_VLEAD: r_d.state = ST_ACTIVE;
                    default:  r_d.state = ST_TAIL;
                endcase
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end
        load = tick && (r_d.state == ST_ACTIVE) && ((r_d.cnt & shift_mask) == '0);
    end

    always_comb begin
        hs_act = (r_q.state == ST_HSYNC);
        vs_act = (r_q.state == ST_ACTIVE) && (r_q.line == '0);
        sc_act = (r_q.state == ST_ACTIVE) && r_q.cnt[cfg_bus_sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_TAIL;
            r_q.cnt   <= '0;
            r_q.line  <= '0;
            r_q.first <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/ptg_stream.sv
module ptg_stream #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              px_valid,
    input  logic [DATA_W-1:0] px_data,
    output logic              px_ready,
    output logic [DATA_W-1:0] pd,
    output logic              urun
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              urun;
    } strm_t;

    strm_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        px_ready = load;
        if (load) begin
            if (px_valid) s_d.data = px_data;
            else          s_d.urun = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.data <= '0;
            s_q.urun <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pd   = s_q.data;
    assign urun = s_q.urun;

endmodule

// File: rtl/passive_lcd_timing.sv
module passive_lcd_timing #(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 8,
    parameter int CNT_W  = 12,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_pix_div,
    input  logic [CNT_W-1:0]  cfg_line_px,
    input  logic [CNT_W-1:0]  cfg_hs_width,
    input  logic [CNT_W-1:0]  cfg_gap_tail,
    input  logic [CNT_W-1:0]  cfg_gap_vs,
    input  logic [1:0]        cfg_bus_sel,
    input  logic [LINE_W-1:0] cfg_frame_lines,
    input  logic              cfg_vs_high,
    input  logic              cfg_hs_high,
    input  logic              cfg_sc_high,
    input  logic              px_valid,
    input  logic [DATA_W-1:0] px_data,
    output logic              px_ready,
    output logic              lcd_vsync,
    output logic              lcd_hsync,
    output logic              lcd_sclk,
    output logic [DATA_W-1:0] lcd_data,
    output logic              underrun
);

    logic tick;
    logic hs_act, vs_act, sc_act, load;

    ptg_pixdiv #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_val (cfg_pix_div),
        .tick    (tick)
    );

    ptg_seq #(.CNT_W(CNT_W), .LINE_W(LINE_W)) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick            (tick),
        .cfg_line_px     (cfg_line_px),
        .cfg_hs_width    (cfg_hs_width),
        .cfg_gap_tail    (cfg_gap_tail),
        .cfg_gap_vs      (cfg_gap_vs),
        .cfg_bus_sel     (cfg_bus_sel),
        .cfg_frame_lines (cfg_frame_lines),
        .hs_act          (hs_act),
        .vs_act          (vs_act),
        .sc_act          (sc_act),
        .load            (load)
    );

    ptg_stream #(.DATA_W(DATA_W)) u_strm (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .px_valid (px_valid),
        .px_data  (px_data),
        .px_ready (px_ready),
        .pd       (lcd_data),
        .urun     (underrun)
    );

    always_comb begin
        lcd_vsync = cfg_vs_high ? vs_act : ~vs_act;
        lcd_hsync = cfg_hs_high ? hs_act : ~hs_act;
        lcd_sclk  = cfg_sc_high ? sc_act : ~sc_act;
    end

endmodule

// File: rtl/ptg_checker.sv
module ptg_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_vs_high,
    input logic              cfg_hs_high,
    input logic              cfg_sc_high,
    input logic              px_valid,
    input logic              px_ready,
    input logic              lcd_vsync,
    input logic              lcd_hsync,
    input logic              lcd_sclk,
    input logic [DATA_W-1:0] lcd_data,
    input logic              underrun
);

    logic vs_on, hs_on, sc_on;
    assign vs_on = (lcd_vsync == cfg_vs_high);
    assign hs_on = (lcd_hsync == cfg_hs_high);
    assign sc_on = (lcd_sclk  == cfg_sc_high);

    AST_SCLK_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        sc_on && $past(sc_on) |-> $stable(lcd_data)); // R10
    AST_READY_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        px_ready |=> !sc_on); // R3
    AST_HOLD_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(px_ready && px_valid) |=> $stable(lcd_data)); // R11
    AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        px_ready && !px_valid |=> underrun); // R11
    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun); // R11
    AST_HS_SCLK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        hs_on |-> !sc_on); // R5
    AST_VS_HS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        vs_on |-> !hs_on); // R8

endmodule

bind passive_lcd_timing ptg_checker #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_vs_high (cfg_vs_high),
    .cfg_hs_high (cfg_hs_high),
    .cfg_sc_high (cfg_sc_high),
    .px_valid    (px_valid),
    .px_ready    (px_ready),
    .lcd_vsync   (lcd_vsync),
    .lcd_hsync   (lcd_hsync),
    .lcd_sclk    (lcd_sclk),
    .lcd_data    (lcd_data),
    .underrun    (underrun)
);

// File: tb/passive_lcd_timing_test.sv
module passive_lcd_timing_test;

    localparam int DW = 16, DIVW = 8, CW = 12, LW = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic            rst_n = 1'b0;
    logic [DIVW-1:0] cfg_pix_div = '0;
    logic [CW-1:0]   cfg_line_px = 12'd4, cfg_hs_width = '0, cfg_gap_tail = '0, cfg_gap_vs = '0;
    logic [1:0]      cfg_bus_sel = '0;
    logic [LW-1:0]   cfg_frame_lines = 10'd1;
    logic            cfg_vs_high = 1'b1, cfg_hs_high = 1'b1, cfg_sc_high = 1'b1;
    logic            px_valid, px_ready;
    logic [DW-1:0]   px_data, lcd_data;
    logic            lcd_vsync, lcd_hsync, lcd_sclk, underrun;

    int checks = 0, errors = 0;
    int sent = 0, limit = 0, cyc = 0;
    int e_p, e_shl, e_half, e_xmax, e_hw, e_w1, e_w2, e_lines;

    assign px_valid = (sent < limit);
    assign px_data  = 16'hA000 + 16'(sent);

    passive_lcd_timing #(.DATA_W(DW), .DIV_W(DIVW), .CNT_W(CW), .LINE_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_pix_div(cfg_pix_div), .cfg_line_px(cfg_line_px),
        .cfg_hs_width(cfg_hs_width), .cfg_gap_tail(cfg_gap_tail), .cfg_gap_vs(cfg_gap_vs),
        .cfg_bus_sel(cfg_bus_sel), .cfg_frame_lines(cfg_frame_lines),
        .cfg_vs_high(cfg_vs_high), .cfg_hs_high(cfg_hs_high), .cfg_sc_high(cfg_sc_high),
        .px_valid(px_valid), .px_data(px_data), .px_ready(px_ready),
        .lcd_vsync(lcd_vsync), .lcd_hsync(lcd_hsync), .lcd_sclk(lcd_sclk),
        .lcd_data(lcd_data), .underrun(underrun)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) sent <= 0;
        else if (px_ready && px_valid) sent <= sent + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // edge monitor, sampled on the falling clock edge
    logic hs_p, vs_p, sc_p;
    int t_hs_r, t_hs_f, t_vs_r, t_sc_r, t_sc_f, ref_t;
    bit have_hsr, have_hsf, have_scf;
    int line_sc, hs_cnt, vs_cnt, words;

    always @(negedge clk) begin
        logic hs, vs, sc;
        int expw;
        hs = (lcd_hsync == cfg_hs_high);
        vs = (lcd_vsync == cfg_vs_high);
        sc = (lcd_sclk  == cfg_sc_high);
        if (!rst_n) begin
            hs_p = 0; vs_p = 0; sc_p = 0;
            have_hsr = 0; have_hsf = 0; have_scf = 0;
            line_sc = 0; hs_cnt = 0; vs_cnt = 0; words = 0;
            t_hs_r = 0; t_hs_f = 0; t_vs_r = 0; t_sc_r = 0; t_sc_f = 0; ref_t = 0;
        end else begin
            if (hs && !hs_p) begin
                if (have_scf) begin
                    chk("R5 tail gap", cyc - t_sc_f, (e_w1 + 1) * e_p);
                    chk("R3 shift clocks per line", line_sc, e_xmax / e_shl);
                end
                line_sc = 0; hs_cnt++; t_hs_r = cyc; have_hsr = 1;
            end
            if (!hs && hs_p) begin
                if (have_hsr) chk("R4 hsync width", cyc - t_hs_r, (e_hw + 1) * e_p);
                t_hs_f = cyc; ref_t = cyc; have_hsf = 1;
            end
            if (vs && !vs_p) begin
                if (have_hsf) chk("R6 hsync to vsync", cyc - t_hs_f, (e_w2 + 2) * e_p);
                if (vs_cnt > 0) chk("R8 hsyncs per frame", hs_cnt, e_lines);
                else            chk("R12 first hsync before vsync", hs_cnt, 1);
                hs_cnt = 0; vs_cnt++; t_vs_r = cyc; ref_t = cyc;
            end
            if (!vs && vs_p) chk("R6 vsync width", cyc - t_vs_r, e_xmax * e_p);
            if (sc && !sc_p) begin
                if (line_sc == 0) begin
                    if (vs) chk("R7 vsync to first sclk", cyc - ref_t, e_half * e_p);
                    else    chk("R6 hsync end to first sclk", cyc - ref_t, e_half * e_p);
                end else begin
                    chk("R1 R2 sclk period", cyc - t_sc_r, e_shl * e_p);
                end
                expw = (words < limit) ? words : limit - 1;
                chk("R10 panel word order", int'(lcd_data), int'(16'hA000 + 16'(expw)));
                chk("R11 underrun flag", int'(underrun), (words >= limit) ? 1 : 0);
                line_sc++; words++; t_sc_r = cyc;
            end
            if (!sc && sc_p) begin
                chk("R2 sclk active half", cyc - t_sc_r, e_half * e_p);
                t_sc_f = cyc; have_scf = 1;
            end
            hs_p = hs; vs_p = vs; sc_p = sc;
        end
    end

    task automatic run_one(input int pcd, input int sel, input int units, input int hw,
                           input int w1, input int w2, input int ln, input int pol, input int lim);
        int guard;
        rst_n = 1'b0;
        e_p = pcd + 1; e_shl = 2 << sel; e_half = 1 << sel; e_xmax = units * e_shl;
        e_hw = hw; e_w1 = w1; e_w2 = w2; e_lines = (ln == 0) ? 1 : ln;
        cfg_pix_div = DIVW'(pcd); cfg_bus_sel = 2'(sel); cfg_line_px = CW'(e_xmax);
        cfg_hs_width = CW'(hw); cfg_gap_tail = CW'(w1); cfg_gap_vs = CW'(w2);
        cfg_frame_lines = LW'(ln);
        cfg_hs_high = pol[0]; cfg_vs_high = pol[1]; cfg_sc_high = pol[2];
        limit = lim;
        repeat (4) @(negedge clk);
        // R12 and R9: reset levels follow the polarity inputs
        chk("R12 R9 hsync idle", int'(lcd_hsync), int'(!pol[0]));
        chk("R12 R9 vsync idle", int'(lcd_vsync), int'(!pol[1]));
        chk("R12 R9 sclk idle",  int'(lcd_sclk),  int'(!pol[2]));
        chk("R12 data zero", int'(lcd_data), 0);
        chk("R12 underrun low", int'(underrun), 0);
        rst_n = 1'b1;
        guard = 0;
        while (vs_cnt < 3 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk("R8 frames produced", (vs_cnt >= 3) ? 1 : 0, 1);
        chk("R11 final underrun", int'(underrun), (lim < (1 << 20)) ? 1 : 0);
    endtask

    initial begin
        for (int i = 0; i < 6; i++)
            run_one(i % 3, i / 3, 3, i % 3, (i + 1) % 3, i % 2, 2 + i % 2, i, 1 << 30);
        run_one(0, 2, 2, 0, 0, 0, 1, 7, 1 << 30);
        run_one(1, 3, 1, 2, 1, 3, 2, 2, 1 << 30);
        run_one(0, 0, 4, 1, 0, 0, 0, 5, 1 << 30);
        run_one(1, 0, 3, 1, 1, 1, 2, 3, 5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule